// File: doc/BRIEF.md
# Sum Window Scaler, Limiter and Rounder

This block narrows a wide signed summation result to an 18-bit sample. A programmable offset picks which 18-bit slice of the 26-bit word is kept, which applies a power-of-two gain. Any input whose magnitude does not fit that slice is hard-limited to the largest positive or most negative 18-bit value, and is never wrapped. The limited value is then rounded to one of four precisions (18, 16, 14 or 12 bits). The result stays aligned to the top of the 18-bit word, and the bits below the chosen precision are cleared.

Two lanes, I and Q, are processed side by side under the same offset and precision controls. A sample is taken in whenever the input valid flag is high. The result appears one clock later with its own valid flag, and between samples the output holds its last value. The block has no state machine: it is a combinational window/limit stage and a rounding stage feeding one output register per lane.

Top module: `sum_window_rounder`

## Requirements
- R1: With `win_sel` = k (0..8) and `prec_sel` = 0, an input that fits the window (bits 25 down to k+17 all equal) gives an output equal to input bits [k+17:k].
- R2: A `win_sel` value above 8 behaves exactly like 8.
- R3: When the input bits above the window are not all copies of the window's top bit, the output is 18'h1FFFF for a non-negative input and 18'h20000 for a negative input, before rounding.
- R4: `prec_sel` encodes precision: 0 gives 18 bits, 1 gives 16, 2 gives 14 and 3 gives 12. The number of cleared low bits is 2×`prec_sel`.
- R5: Rounding adds one half of the target LSB to the windowed value and then truncates, so ties go toward positive infinity. Input bits below the window have no effect on the result.
- R6: If the half-LSB addition carries past the largest positive value, the output is the largest positive value at that precision (for example 18'h1FFC0 at 12 bits).
- R7: Output bits below the selected precision are always zero.
- R8: The I and Q lanes are computed independently with identical rules.
- R9: Output data and `out_valid` appear exactly one cycle after the input. `out_valid` equals `in_valid` delayed by one clock. Reset clears `out_valid` and both outputs to zero.
- R10: While `in_valid` is low, changes on the data and control inputs leave the output data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_i | input | 26 | I-lane signed sum |
| in_q | input | 26 | Q-lane signed sum |
| win_sel | input | 4 | Low bit index of the kept window (0..8, larger clamps to 8) |
| prec_sel | input | 2 | Rounding precision select |
| out_valid | output | 1 | Output sample valid |
| out_i | output | 18 | I-lane result, MSB-justified |
| out_q | output | 18 | Q-lane result, MSB-justified |

## Verification
The hardest situation to reach from the ports is the rounding carry into saturation. It needs a windowed value within half an LSB of the positive limit at a coarse precision, which uniform random 26-bit words almost never produce. Ties at the exact half point are just as rare. Directed cases place values at the limit, at exact ties and just below the window. The random stimulus shifts each word right by a random amount, which spreads magnitudes across every window offset so that values near the overflow boundary come up often.

// File: rtl/swsr_pkg.sv
package swsr_pkg;

    // Bits dropped per step of the precision select
    localparam int SWSR_STEP = 2;

    typedef enum logic [1:0] {
        PREC_18 = 2'd0,
        PREC_16 = 2'd1,
        PREC_14 = 2'd2,
        PREC_12 = 2'd3
    } prec_e;

    function automatic int drop_of(prec_e p);
        return SWSR_STEP * int'(p);
    endfunction

endpackage

// File: rtl/swsr_window.sv
module swsr_window #(
    parameter int IN_W  = 26,
    parameter int OUT_W = 18,
    localparam int MAX_OFF = IN_W - OUT_W,
    localparam int SEL_W   = $clog2(MAX_OFF + 1)
) (
    input  logic [IN_W-1:0]  din,
    input  logic [SEL_W-1:0] off,
    output logic [OUT_W-1:0] dout
);
    localparam int HEAD_W = IN_W - OUT_W + 1;

    logic [SEL_W-1:0]       off_c;
    logic signed [IN_W-1:0] shifted;
    logic [HEAD_W-1:0]      head;
    logic                   ovf;

    always_comb begin
        off_c   = (off > SEL_W'(MAX_OFF)) ? SEL_W'(MAX_OFF) : off;
        shifted = $signed(din) >>> off_c;
        head    = shifted[IN_W-1:OUT_W-1];
        ovf     = !((&head) || (~|head));
        if (ovf)
            dout = shifted[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                   : {1'b0, {(OUT_W-1){1'b1}}};
        else
            dout = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/swsr_round.sv
module swsr_round #(
    parameter int OUT_W = 18,
    parameter int STEP  = 2,
    parameter int NPREC = 4,
    localparam int PSEL_W = $clog2(NPREC)
) (
    input  logic [OUT_W-1:0]  din,
    input  logic [PSEL_W-1:0] prec,
    output logic [OUT_W-1:0]  dout
);
    logic [OUT_W-1:0] cand [NPREC];

    for (genvar p = 0; p < NPREC; p++) begin : g_prec
        localparam int D = STEP * p;
        if (D == 0) begin : g_full
            assign cand[p] = din;
        end else begin : g_cut
            localparam logic [OUT_W-1:0] LOWM = OUT_W'((1 << D) - 1);
            localparam logic [OUT_W:0]   HALF = (OUT_W+1)'(1 << (D - 1));
            logic [OUT_W:0] sum;
            logic           carry_ovf;
            assign sum       = {din[OUT_W-1], din} + HALF;
            assign carry_ovf = (sum[OUT_W:OUT_W-1] == 2'b01);
            assign cand[p]   = carry_ovf ? ({1'b0, {(OUT_W-1){1'b1}}} & ~LOWM)
                                         : (sum[OUT_W-1:0] & ~LOWM);
        end
    end

    assign dout = cand[prec];
endmodule

// File: rtl/sum_window_rounder.sv
module sum_window_rounder
    import swsr_pkg::*;
#(
    parameter int IN_W  = 26,
    parameter int OUT_W = 18,
    localparam int SEL_W  = $clog2(IN_W - OUT_W + 1),
    localparam int PSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_i,
    input  logic [IN_W-1:0]   in_q,
    input  logic [SEL_W-1:0]  win_sel,
    input  logic [PSEL_W-1:0] prec_sel,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q
);
    localparam int LANES = 2;

    logic [IN_W-1:0]  lane_in  [LANES];
    logic [OUT_W-1:0] lane_win [LANES];
    logic [OUT_W-1:0] lane_rnd [LANES];
    logic [OUT_W-1:0] lane_q   [LANES];
    logic             valid_q;

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        swsr_window #(.IN_W(IN_W), .OUT_W(OUT_W)) u_win (
            .din  (lane_in[l]),
            .off  (win_sel),
            .dout (lane_win[l])
        );
        swsr_round #(.OUT_W(OUT_W), .STEP(SWSR_STEP), .NPREC(4)) u_rnd (
            .din  (lane_win[l]),
            .prec (prec_sel),
            .dout (lane_rnd[l])
        );
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[l] <= '0;
            else if (in_valid)
                lane_q[l] <= lane_rnd[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    assign out_valid = valid_q;
    assign out_i     = lane_q[0];
    assign out_q     = lane_q[1];

    // R9: valid tracks input valid with one cycle of latency
    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7: low bits below the chosen precision are zero
    assert_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n)) |->
        ((out_i & OUT_W'((1 << drop_of(prec_e'($past(prec_sel)))) - 1)) == '0));

    // R3: most negative input always limits to the negative extreme
    assert_neg_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n) && ($past(in_i) == {1'b1, {(IN_W-1){1'b0}}})) |->
        (out_i == {1'b1, {(OUT_W-1){1'b0}}}));

    // R6: largest positive input lands on the positive limit at the precision
    assert_pos_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n) && ($past(in_i) == {1'b0, {(IN_W-1){1'b1}}})) |->
        (out_i == ({1'b0, {(OUT_W-1){1'b1}}} &
                   ~OUT_W'((1 << drop_of(prec_e'($past(prec_sel)))) - 1))));

    // R5: a non-negative input never yields a negative result
    assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n) && !$past(in_q[IN_W-1])) |-> !out_q[OUT_W-1]);

    // R10: data holds while no sample is taken
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/tb_sum_window_rounder.sv
module tb_sum_window_rounder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [25:0] in_i = '0, in_q = '0;
    logic [3:0]  win_sel = '0;
    logic [1:0]  prec_sel = '0;
    logic        out_valid;
    logic [17:0] out_i, out_q;

    int checks = 0;
    int errors = 0;

    sum_window_rounder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .win_sel(win_sel), .prec_sel(prec_sel),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #10 clk = ~clk;

    function automatic logic [17:0] model(logic [25:0] x, int win, int prec);
        longint v = longint'($signed(x));
        int off = (win > 8) ? 8 : win;
        int d = 2 * prec;
        longint q = longint'(1) << d;
        longint top = 131072 - q;
        v = v >>> off;
        if (v > 131071) v = 131071;
        if (v < -131072) v = -131072;
        v = ((v + q / 2) >>> d) <<< d;
        if (v > top) v = top;
        return v[17:0];
    endfunction

    task automatic check(string tag, logic [17:0] got, logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(logic [25:0] xi, logic [25:0] xq, int win, int prec);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = xi; in_q = xq;
        win_sel = 4'(win); prec_sel = 2'(prec);
        @(posedge clk);
        #1;
    endtask

    task automatic run(string tag, logic [25:0] xi, int win, int prec, logic [17:0] exp);
        drive(xi, 26'h0, win, prec);
        check(tag, out_i, exp);
        check(tag, {17'b0, out_valid}, 18'd1);
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset valid", {17'b0, out_valid}, 18'd0);
        check("R9 reset out_i", out_i, 18'd0);
        check("R9 reset out_q", out_q, 18'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run("R1 window 4", 26'h0012345, 4, 0, 18'h01234);
        run("R1 window 0", 26'h001ABCD, 0, 0, 18'h1ABCD);
        run("R1 window 8", 26'h1234567, 8, 0, 18'h12345);
        run("R2 clamp 12", 26'h1234567, 12, 0, 18'h12345);
        run("R2 clamp 15", 26'h3ABCDEF, 15, 0, model(26'h3ABCDEF, 8, 0));
        run("R3 pos limit", 26'h0100000, 0, 0, 18'h1FFFF);
        run("R3 neg limit", 26'h3F00000, 0, 0, 18'h20000);
        run("R4 prec 16", 26'h0001237, 0, 1, 18'h01238);
        run("R4 prec 12", 26'h000007F, 0, 3, 18'h00080);
        run("R5 tie pos", 26'h0000002, 0, 1, 18'h00004);
        run("R5 tie neg", 26'h3FFFFFE, 0, 1, 18'h00000);
        run("R5 below window", 26'h000000F, 4, 0, 18'h00000);
        run("R5 below window 2", 26'h000001F, 4, 0, 18'h00001);
        run("R6 carry 12", 26'h001FFFF, 0, 3, 18'h1FFC0);
        run("R6 carry 16", 26'h001FFFE, 0, 1, 18'h1FFFC);
        run("R7 neg 14", 26'h3FFFFF3, 0, 2, 18'h3FFF0);

        drive(26'h0000444, 26'h3FFF000, 0, 0);
        check("R8 lane I", out_i, 18'h00444);
        check("R8 lane Q", out_q, 18'h3F000);

        @(negedge clk);
        in_valid = 1'b0;
        in_i = 26'h1555555; in_q = 26'h2AAAAAA; prec_sel = 2'd3; win_sel = 4'd2;
        @(posedge clk);
        #1;
        check("R10 hold I", out_i, 18'h00444);
        check("R10 hold Q", out_q, 18'h3F000);
        check("R9 valid low", {17'b0, out_valid}, 18'd0);

        for (int n = 0; n < 3000; n++) begin
            logic [25:0] xi, xq;
            int w, p;
            xi = 26'($urandom) >> ($urandom % 26);
            if ($urandom % 2 == 1) xi = -xi;
            xq = 26'($urandom) >> ($urandom % 26);
            if ($urandom % 2 == 1) xq = -xq;
            w = int'($urandom % 16);
            p = int'($urandom % 4);
            drive(xi, xq, w, p);
            check("R1 random I", out_i, model(xi, w, p));
            check("R8 random Q", out_q, model(xq, w, p));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule